// File: doc/BRIEF.md
# Return Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small microcontroller core. It has eight levels and holds program-counter values only. A subroutine call or a granted interrupt writes the current program counter into the next free level. A return or an interrupt return takes the newest level back out. The popped address appears combinationally on `ret_pc_o` in the same cycle that `ret_i` is high, so the core can load it at the same clock edge. Software has no way to read or write the levels or the pointer.

The stack protects itself differently for the two kinds of push:

- **Interrupts.** An interrupt request is always latched. While all levels are occupied, the grant on `irq_ack_o` is held back. The first return frees a level, and the waiting interrupt is granted on a later cycle.
- **Calls.** A call made while the stack is full is never refused. The storage behaves as a ring, so the oldest address is overwritten and the newest eight remain.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, the stack is empty: `full_o` is 0, and `irq_ack_o` is 0 while no interrupt request is present.
- R2: A cycle with `call_i`=1 and `ret_i`=0 stores `pc_i`. In a later cycle with `ret_i`=1, `ret_pc_o` equals the newest stored value.
- R3: Returns deliver the stored addresses in reverse order of storage (last in, first out).
- R4: `full_o` is 1 exactly when eight addresses are held.
- R5: With the stack not full and neither `call_i` nor `ret_i` high, an interrupt request raises `irq_ack_o` in the same cycle. `pc_i` of that cycle is stored, and the grant lasts a single cycle unless a new request arrives.
- R6: While `full_o` is 1, `irq_ack_o` stays 0, and a request seen in that time is kept pending.
- R7: A pending interrupt is granted in the first cycle after a return that has freed a level, provided `call_i` and `ret_i` are then 0.
- R8: A call while `full_o` is 1 overwrites the oldest address. `full_o` stays 1, and the next eight returns give the eight newest addresses.
- R9: When `ret_i` and `call_i` are both 1 in one cycle, only the pop takes place and the call is ignored. `irq_ack_o` is 0 in any cycle where `call_i` or `ret_i` is 1.
- R10: A return on an empty stack raises no flag and leaves `full_o` at 0. A following call and return still give back the called address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Subroutine call: push `pc_i` |
| irq_req_i | input | 1 | Unmasked interrupt request, latched until granted |
| ret_i | input | 1 | Return or interrupt return: pop |
| pc_i | input | PC_W | Return address to store |
| ret_pc_o | output | PC_W | Newest stored address (valid when stack not empty) |
| full_o | output | 1 | All eight levels occupied |
| irq_ack_o | output | 1 | Interrupt grant; a push happens in the same cycle |

## Verification
The assertions check the following on every cycle:
- the grant never coincides with a full stack, a call or a return;
- a return always clears `full_o`;
- `full_o` only rises after a push;
- a call on a full stack keeps it full;
- a grant does not repeat without a new request.

Some behaviour depends on stored data or on history, so only the bench scenarios can show it:
- the last-in-first-out order of the returned addresses;
- which address is lost when a call overwrites the oldest level;
- that a call in the same cycle as a return leaves nothing behind;
- that a request held during a full stack is granted after the return.

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int PC_W  = 11,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            irq_req_i,
  input  logic            ret_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            full_o,
  output logic            irq_ack_o
);
  // DEPTH must be a power of two so the write pointer wraps as a ring.
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wp;
  logic [CNT_W-1:0] cnt;
  logic             pend_q;
  logic             req, push;

  assign full_o    = (cnt == CNT_W'(DEPTH));
  assign req       = pend_q | irq_req_i;
  assign irq_ack_o = req & ~full_o & ~ret_i & ~call_i;
  assign push      = ~ret_i & (call_i | irq_ack_o);
  assign ret_pc_o  = mem[wp - PTR_W'(1)];

  always_ff @(posedge clk)
    if (push) mem[wp] <= pc_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      cnt    <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= req & ~irq_ack_o;
      if (ret_i) begin
        wp <= wp - PTR_W'(1);
        if (cnt != '0) cnt <= cnt - CNT_W'(1);
      end else if (push) begin
        wp <= wp + PTR_W'(1);
        if (!full_o) cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk (
  input logic clk,
  input logic rst_n,
  input logic call_i,
  input logic irq_req_i,
  input logic ret_i,
  input logic full_o,
  input logic irq_ack_o
);
  // R6
  no_ack_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ack_o);

  // R9
  no_ack_with_call_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || ret_i) |-> !irq_ack_o);

  // R7
  ret_frees_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> !full_o);

  // R4
  full_rise_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) |-> $past(call_i || irq_ack_o));

  // R8
  call_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && call_i && !ret_i) |=> full_o);

  // R5
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |=> (!irq_ack_o || irq_req_i));
endmodule

bind ret_addr_stack ret_addr_stack_chk chk_i (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .irq_req_i(irq_req_i),
  .ret_i(ret_i), .full_o(full_o), .irq_ack_o(irq_ack_o));

// File: tb/ret_addr_stack_tb_top.sv
module ret_addr_stack_tb_top;
  localparam int PC_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic call_i = 0, irq_req_i = 0, ret_i = 0;
  logic [PC_W-1:0] pc_i = '0;
  logic [PC_W-1:0] ret_pc_o;
  logic full_o, irq_ack_o;

  int checks = 0, fails = 0;
  int model[$];
  int exp_pc[$];
  string exp_tag[$];
  bit pend_m = 0;

  always #2 clk = ~clk;

  ret_addr_stack #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .irq_req_i(irq_req_i),
    .ret_i(ret_i), .pc_i(pc_i), .ret_pc_o(ret_pc_o), .full_o(full_o),
    .irq_ack_o(irq_ack_o));

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ret_i && exp_pc.size() > 0) begin
      automatic int e = exp_pc.pop_front();
      automatic string t = exp_tag.pop_front();
      if (e >= 0) check(t, "ret_pc", int'(ret_pc_o), e);
    end
  end

  task automatic step(bit c, bit irq, bit r, int pc, string tag);
    bit ack_e;
    @(posedge clk); #1;
    call_i = c; irq_req_i = irq; ret_i = r; pc_i = PC_W'(pc);
    ack_e = (pend_m | irq) & (model.size() < 8) & !r & !c;
    if (r) begin
      exp_pc.push_back(model.size() > 0 ? model[$] : -1);
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    check(tag, "full", int'(full_o), int'(model.size() == 8));
    check(tag, "ack", int'(irq_ack_o), int'(ack_e));
    if (r) begin
      if (model.size() > 0) void'(model.pop_back());
    end else if (c || ack_e) begin
      if (model.size() == 8) void'(model.pop_front());
      model.push_back(pc);
    end
    pend_m = (pend_m | irq) & !ack_e;
  endtask

  task automatic idle(string tag);  step(0, 0, 0, 0, tag); endtask
  task automatic do_call(int pc, string tag); step(1, 0, 0, pc, tag); endtask
  task automatic do_ret(string tag); step(0, 0, 1, 0, tag); endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1");
    // R2 / R3
    do_call(100, "R2"); do_call(101, "R2"); do_call(102, "R2");
    do_ret("R2"); do_ret("R3"); do_ret("R3");
    // R5
    step(0, 1, 0, 300, "R5");
    idle("R5");
    do_ret("R5");
    // R4: fill eight levels
    for (int i = 0; i < 8; i++) do_call(200 + i, "R4");
    idle("R4");
    // R6 / R7
    step(0, 1, 0, 400, "R6");
    idle("R6");
    do_ret("R7");
    step(0, 0, 0, 500, "R7");
    idle("R7");
    do_ret("R7");
    // R8: overflow by two calls on a full stack
    do_call(600, "R8");
    do_call(601, "R8");
    do_call(602, "R8");
    for (int i = 0; i < 8; i++) do_ret("R8");
    idle("R8");
    // R9
    do_call(700, "R9");
    do_call(701, "R9");
    step(1, 0, 1, 702, "R9");
    do_ret("R9");
    step(1, 1, 0, 703, "R9");
    do_ret("R9");
    do_ret("R9");
    // R10
    do_ret("R10");
    idle("R10");
    do_call(85, "R10");
    do_ret("R10");
    idle("R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule